// File: doc/BRIEF.md
# Glitch-Free Gated Differential Clock Fanout

This block takes one input clock and fans it out to a parameterised number of differential output pairs (ten by default) and one feedback output. Each pair has a true line that follows the input clock and a complement line that is its inverse. Every pair has its own enable bit. A disabled pair goes to high impedance. The model shows this as an output-enable line driven low, with both data lines held at 0. The feedback output ignores the enable bits.

Each enable bit is synchronised into the input-clock domain and applied on a falling edge of the input clock. A pair therefore starts or stops only during a low phase, and no shortened pulse reaches the pins. A frequency monitor runs on a free-running reference clock. It counts rising edges of the input clock in fixed windows. When a window contains too few edges, the monitor forces every pair and the feedback output to high impedance. Two good windows in a row lift the force. A bypass mode, used when the on-chip loop is switched off for test, passes the input clock straight through and is not affected by the low-frequency force.

Top module: `diff_clock_fanout`

## Requirements
- R1: Pair i drives (yOe[i]=1) when enableVec[i] is 1. It is in high impedance (yOe[i]=0, yTrue[i]=0, yComp[i]=0) when enableVec[i] is 0. The bit takes effect at the first falling edge of clkIn that follows SYNC_STAGES rising edges of clkIn.
- R2: fbOe does not depend on enableVec. It is 1 unless the low-frequency force is active.
- R3: yOe bits change in response to enableVec only while clkIn is low, so no pair emits a partial high pulse.
- R4: On a driving pair, yTrue equals clkIn and yComp equals its inverse. fbOut equals clkIn while fbOe is 1.
- R5: While rstN is low, and after reset until a new enable value has passed through the synchroniser, every pair is enabled, whatever the value of enableVec.
- R6: Windows of REF_WINDOW refClk cycles start at reset release. A window is bad when it holds fewer than MIN_EDGES rising edges of clkIn. One refClk cycle after a bad window ends, all yOe bits and fbOe are 0, and enableVec has no effect while the force lasts.
- R7: Once forced, outputs stay forced after the first good window. The force is removed one refClk cycle after the end of the second good window in a row.
- R8: While bypassMode is 1, the low-frequency force is held off one refClk cycle after bypassMode rises, and the outputs follow clkIn with the polarity of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock for the frequency monitor |
| rstN | input | 1 | Asynchronous active-low reset |
| clkIn | input | 1 | Clock to be distributed |
| bypassMode | input | 1 | 1 = loop bypassed for test; low-frequency force disabled |
| enableVec | input | NUM_PAIRS | Per-pair enable, 1 = drive |
| yTrue | output | NUM_PAIRS | True line of each pair |
| yComp | output | NUM_PAIRS | Complement line of each pair |
| yOe | output | NUM_PAIRS | Modelled output enable of each pair |
| fbOut | output | 1 | Feedback clock output |
| fbOe | output | 1 | Modelled output enable of the feedback output |

## Verification
The gate-hold assertion relies on each clkIn phase being longer than one refClk period. Under that condition, two consecutive reference samples that both see clkIn high belong to the same high phase. The stimulus uses only 50 MHz and 10 MHz input clocks against the 125 MHz reference for this reason. The monitor assertions treat clkIn as a level that may be sampled at any time, so the bench changes clkIn frequency only just after a window boundary. That lets it predict exactly which window first looks bad or good. enableVec is driven at arbitrary phases of clkIn, both high and low, because the synchroniser is expected to absorb the asynchrony.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  // Strobes from the frequency control to the output datapath
  typedef struct packed {
    logic forceOff;   // all outputs to high impedance
  } outStrobes_t;

endpackage

// File: rtl/clkfan_freq_ctrl.sv
module clkfan_freq_ctrl
  import clkfan_pkg::*;
#(
  parameter int REF_WINDOW  = 64,
  parameter int MIN_EDGES   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        clkIn,
  input  logic        bypassMode,
  output outStrobes_t strobes
);

  localparam int WIN_W = (REF_WINDOW > 1) ? $clog2(REF_WINDOW) : 1;
  localparam int CNT_W = $clog2(REF_WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(REF_WINDOW - 1);
  localparam logic [CNT_W-1:0] EDGE_MIN = CNT_W'(MIN_EDGES);

  logic [SYNC_STAGES-1:0] clkSync;
  logic                   clkPrev;
  logic                   risePulse;
  logic [WIN_W-1:0]       winCnt;
  logic                   windowEnd;
  logic [CNT_W-1:0]       edgeCnt;
  logic [CNT_W-1:0]       totalEdges;
  logic                   windowGood;
  logic                   lowFreq;
  logic                   goodRun;
  logic                   forceOffQ;

  // Bring the input clock level into the reference domain
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], clkIn};
      clkPrev <= clkSync[SYNC_STAGES-1];
    end
  end

  assign risePulse = clkSync[SYNC_STAGES-1] & ~clkPrev;

  // Measurement window
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else if (windowEnd) winCnt <= '0;
    else winCnt <= winCnt + 1'b1;
  end

  assign windowEnd  = (winCnt == WIN_LAST);
  assign totalEdges = edgeCnt + CNT_W'(risePulse);
  assign windowGood = (totalEdges >= EDGE_MIN);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (windowEnd) edgeCnt <= '0;
    else edgeCnt <= totalEdges;
  end

  // Low-frequency decision with two-window recovery
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lowFreq <= 1'b0;
      goodRun <= 1'b0;
    end else if (windowEnd) begin
      if (!windowGood) begin
        lowFreq <= 1'b1;
        goodRun <= 1'b0;
      end else if (lowFreq) begin
        if (goodRun) begin
          lowFreq <= 1'b0;
          goodRun <= 1'b0;
        end else begin
          goodRun <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) forceOffQ <= 1'b0;
    else forceOffQ <= lowFreq & ~bypassMode;
  end

  assign strobes.forceOff = forceOffQ;

  AST_SLOW_FROM_BAD: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lowFreq) |-> ($past(windowEnd) && ($past(totalEdges) < EDGE_MIN))); // R6

  AST_RECOVER_TWO: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lowFreq) |-> ($past(windowEnd) && $past(goodRun) && $past(windowGood))); // R7

  AST_BYPASS_NO_FORCE: assert property (@(posedge refClk) disable iff (!rstN)
    $past(bypassMode) |-> !strobes.forceOff); // R8

  AST_EDGE_BOUND: assert property (@(posedge refClk) disable iff (!rstN)
    windowEnd |=> (edgeCnt <= CNT_W'(1))); // R6

endmodule

// File: rtl/clkfan_out_path.sv
module clkfan_out_path
  import clkfan_pkg::*;
#(
  parameter int NUM_PAIRS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 clkIn,
  input  logic [NUM_PAIRS-1:0] enableVec,
  input  outStrobes_t          strobes,
  output logic [NUM_PAIRS-1:0] yTrue,
  output logic [NUM_PAIRS-1:0] yComp,
  output logic [NUM_PAIRS-1:0] yOe,
  output logic                 fbOut,
  output logic                 fbOe
);

  logic [NUM_PAIRS-1:0] gate;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic [SYNC_STAGES-1:0] enSync;

    // Enable synchroniser on the rising edge of the distributed clock
    always_ff @(posedge clkIn or negedge rstN) begin
      if (!rstN) enSync <= '1;
      else enSync <= {enSync[SYNC_STAGES-2:0], enableVec[i]};
    end

    // Applied on the falling edge: the gate only moves during a low phase
    always_ff @(negedge clkIn or negedge rstN) begin
      if (!rstN) gate[i] <= 1'b1;
      else gate[i] <= enSync[SYNC_STAGES-1];
    end

    assign yOe[i]   = gate[i] & ~strobes.forceOff;
    assign yTrue[i] = yOe[i] & clkIn;
    assign yComp[i] = yOe[i] & ~clkIn;

    AST_GATE_HIGH_HOLD: assert property (@(posedge refClk) disable iff (!rstN)
      (clkIn && $past(clkIn)) |-> $stable(gate[i])); // R3
  end

  assign fbOe  = ~strobes.forceOff;
  assign fbOut = fbOe & clkIn;

endmodule

// File: rtl/diff_clock_fanout.sv
module diff_clock_fanout
  import clkfan_pkg::*;
#(
  parameter int NUM_PAIRS   = 10,
  parameter int REF_WINDOW  = 64,
  parameter int MIN_EDGES   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 clkIn,
  input  logic                 bypassMode,
  input  logic [NUM_PAIRS-1:0] enableVec,
  output logic [NUM_PAIRS-1:0] yTrue,
  output logic [NUM_PAIRS-1:0] yComp,
  output logic [NUM_PAIRS-1:0] yOe,
  output logic                 fbOut,
  output logic                 fbOe
);

  outStrobes_t strobes;

  clkfan_freq_ctrl #(
    .REF_WINDOW (REF_WINDOW),
    .MIN_EDGES  (MIN_EDGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .clkIn     (clkIn),
    .bypassMode(bypassMode),
    .strobes   (strobes)
  );

  clkfan_out_path #(
    .NUM_PAIRS  (NUM_PAIRS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .refClk   (refClk),
    .rstN     (rstN),
    .clkIn    (clkIn),
    .enableVec(enableVec),
    .strobes  (strobes),
    .yTrue    (yTrue),
    .yComp    (yComp),
    .yOe      (yOe),
    .fbOut    (fbOut),
    .fbOe     (fbOe)
  );

endmodule

// File: tb/diff_clock_fanout_bench.sv
`timescale 1ns/1ps
module diff_clock_fanout_bench;

  localparam int NP  = 10;
  localparam int WIN = 64;
  localparam int MINE = 10;
  localparam logic [NP-1:0] ALL = '1;

  logic          refClk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkIn = 1'b0;
  logic          bypassMode = 1'b0;
  logic [NP-1:0] enableVec = '0;
  logic [NP-1:0] yTrue, yComp, yOe;
  logic          fbOut, fbOe;

  int  checks = 0;
  int  fails = 0;
  int  refCount = 0;
  int  clkHalf = 10;
  bit  runtWatch = 1'b0;
  bit  done = 1'b0;

  diff_clock_fanout #(
    .NUM_PAIRS(NP), .REF_WINDOW(WIN), .MIN_EDGES(MINE), .SYNC_STAGES(2)
  ) u_diff_clock_fanout (
    .refClk(refClk), .rstN(rstN), .clkIn(clkIn), .bypassMode(bypassMode),
    .enableVec(enableVec), .yTrue(yTrue), .yComp(yComp), .yOe(yOe),
    .fbOut(fbOut), .fbOe(fbOe)
  );

  always #4 refClk = ~refClk;
  always #(clkHalf) clkIn = ~clkIn;

  always @(posedge refClk) if (rstN) refCount <= refCount + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R3: a pair enable may only move while clkIn is low
  always @(yOe) begin
    if (rstN && runtWatch) check(clkIn === 1'b0, "R3 enable moved in high phase",
                                 {31'd0, clkIn}, 32'd0);
  end

  task automatic waitRef(input int target);
    while (refCount < target) @(posedge refClk);
    #2;
  endtask

  function automatic int nextBoundary();
    return ((refCount / WIN) + 1) * WIN;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int b;
    // R5: reset state, enable input held at zero
    #30;
    check(yOe === ALL, "R5 reset yOe", 32'(yOe), 32'(ALL));
    check(fbOe === 1'b1, "R5 reset fbOe", {31'd0, fbOe}, 32'd1);
    @(negedge refClk);
    rstN = 1'b1;
    #3;
    check(yOe === ALL, "R5 after release before sync", 32'(yOe), 32'(ALL));
    enableVec = ALL;
    runtWatch = 1'b1;

    // R1 R2 R4: exhaustive sweep of the enable vector, changes at both phases
    for (int p = 0; p < (1 << NP); p++) begin
      logic [NP-1:0] pat;
      pat = NP'(p);
      if (p % 2 == 1) begin @(posedge clkIn); #3; end
      else begin @(negedge clkIn); #3; end
      enableVec = pat;
      repeat (2) @(posedge clkIn);
      @(negedge clkIn); #3;
      check(yOe === pat, "R1 yOe follows enable", 32'(yOe), 32'(pat));
      check(fbOe === 1'b1, "R2 feedback enabled", {31'd0, fbOe}, 32'd1);
      check(yComp === pat, "R4 low phase complement", 32'(yComp), 32'(pat));
      check(yTrue === '0, "R4 low phase true", 32'(yTrue), 32'd0);
      @(posedge clkIn); #3;
      check(yTrue === pat, "R4 high phase true", 32'(yTrue), 32'(pat));
      check(yComp === '0, "R1 R4 high phase complement", 32'(yComp), 32'd0);
      check(fbOut === 1'b1, "R4 feedback high", {31'd0, fbOut}, 32'd1);
    end

    // R6: slow input forces high impedance after one bad window
    runtWatch = 1'b0;
    enableVec = 10'h3A5;
    b = nextBoundary();
    waitRef(b);
    clkHalf = 50;
    waitRef(b + WIN - 2);
    check(yOe === 10'h3A5, "R6 no force before window end", 32'(yOe), 32'h3A5);
    waitRef(b + WIN + 1);
    check(yOe === '0, "R6 pairs forced off", 32'(yOe), 32'd0);
    check(fbOe === 1'b0, "R6 feedback forced off", {31'd0, fbOe}, 32'd0);
    enableVec = ALL;
    @(posedge clkIn); #3;
    check(yTrue === '0 && fbOut === 1'b0, "R6 outputs quiet", 32'(yTrue), 32'd0);
    waitRef(refCount + 20);
    check(yOe === '0, "R6 enable ignored while forced", 32'(yOe), 32'd0);

    // R8: bypass lifts the force while the input stays slow
    bypassMode = 1'b1;
    waitRef(refCount + 2);
    check(yOe === ALL, "R8 bypass pairs on", 32'(yOe), 32'(ALL));
    check(fbOe === 1'b1, "R8 bypass feedback on", {31'd0, fbOe}, 32'd1);
    @(posedge clkIn); #3;
    check(yTrue === ALL && yComp === '0, "R8 bypass high phase", 32'(yTrue), 32'(ALL));
    @(negedge clkIn); #3;
    check(yComp === ALL && fbOut === 1'b0, "R8 bypass low phase", 32'(yComp), 32'(ALL));
    bypassMode = 1'b0;
    waitRef(refCount + 2);
    check(yOe === '0, "R6 force returns without bypass", 32'(yOe), 32'd0);

    // R7: recovery needs two good windows in a row
    b = nextBoundary();
    waitRef(b);
    clkHalf = 10;
    waitRef(b + WIN + 1);
    check(yOe === '0, "R7 one good window not enough", 32'(yOe), 32'd0);
    check(fbOe === 1'b0, "R7 feedback still off", {31'd0, fbOe}, 32'd0);
    waitRef(b + 2 * WIN - 1);
    check(yOe === '0, "R7 still off before second end", 32'(yOe), 32'd0);
    waitRef(b + 2 * WIN + 1);
    check(yOe === ALL, "R7 pairs recovered", 32'(yOe), 32'(ALL));
    check(fbOe === 1'b1, "R7 feedback recovered", {31'd0, fbOe}, 32'd1);
    @(posedge clkIn); #3;
    check(yTrue === ALL && fbOut === 1'b1, "R4 after recovery", 32'(yTrue), 32'(ALL));

    finishRun();
  end

endmodule